// File: doc/BRIEF.md
# Background Tile Pixel Shifter

This block turns fetched tile data into one background palette index per pixel clock for a tile-based video generator. Each tile brings two pattern bytes (one per bit-plane) and a 2-bit palette-select value. The pattern bytes go into the upper half of two 16-bit shift registers while the lower half is still being displayed. The palette-select bits are fed serially into two 8-bit shift registers. All four registers move one position toward bit 0 on every enabled pixel clock.

Fine horizontal scroll is not applied as a pre-shift. A 3-bit value selects the same tap, bit 0 to bit 7, in all four registers, and the four tapped bits form the index. The fetch-to-pixel delay is therefore fixed by construction and falls by one clock for each step of scroll. The upstream fetch logic asserts the load strobe on the last enabled clock of each 8-clock fetch phase. Memory access, colour lookup and sprites are handled elsewhere.

Top module: `bgpix_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four shift registers and the attribute latch, so `pix_idx` is 0 after that edge whatever `fine_x` is, and stays 0 until loaded tile data reaches the tap.
- R2: On every rising edge with `pix_en` high and `load` low, each pattern register moves right by one bit and a 0 enters bit 15.
- R3: On a rising edge with `pix_en` and `load` both high, each pattern register first moves right by one bit, then bits 15:8 are overwritten with its pattern byte in reversed bit order, so byte bit 7 (the leftmost pixel) lands in bit 8. No further shift happens on that edge.
- R4: A load edge also captures `attr` into a latch. On every enabled edge, each attribute register moves right by one bit and its latched bit enters bit 7, so a tile's palette-select first enters one enabled edge after its load edge.
- R5: `pix_idx` bit 3 is attribute register 1 (from `attr[1]`) at tap `fine_x`, bit 2 is attribute register 0 at that tap, bit 1 is the `plane_hi` register at that tap and bit 0 is the `plane_lo` register at that tap.
- R6: Take a fetch phase that starts at enabled edge count k and whose load is the (k+8)th enabled edge. With scroll n, pixel p (0 = leftmost) of that tile is shown after enabled edge k+16−n+p, together with that tile's palette-select.
- R7: On an edge with `pix_en` low, all registers and the latch hold, and `load`, `plane_lo`, `plane_hi` and `attr` have no effect.
- R8: `pix_idx` reflects the register contents after all shifts and loads of the latest edge, and `fine_x` acts on it combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable; registers advance only when high |
| load | input | 1 | Load strobe on the last clock of a tile fetch phase |
| plane_lo | input | 8 | Pattern byte for bit-plane 0, MSB = leftmost pixel |
| plane_hi | input | 8 | Pattern byte for bit-plane 1, MSB = leftmost pixel |
| attr | input | 2 | Palette-select bits of the tile being loaded |
| fine_x | input | 3 | Fine horizontal scroll, selects tap 0 to 7 |
| pix_idx | output | 4 | Background palette index of the current pixel |

## Verification
The assertions assume that loads come from a fetcher running on the enabled clock. A load only counts with `pix_en` high, and the attribute-entry property assumes two adjacent enabled edges after a load. They also assume that `rst` is high from time zero. The stimulus keeps loads exactly eight enabled edges apart and drops `pix_en` at random to create gaps. While `pix_en` is low, and on enabled edges with `load` low, it drives junk bytes, junk attributes and stray load pulses. It changes `fine_x` freely, because the tap is combinational and the expected pixel is worked out from the current scroll value on every cycle.

// File: rtl/bgpix_shifter_pkg.sv
package bgpix_shifter_pkg;

    // Four-bit background index: palette select on top, pattern planes below.
    typedef struct packed {
        logic pal_hi;
        logic pal_lo;
        logic pat_hi;
        logic pat_lo;
    } bg_index_t;

endpackage

// File: rtl/bgpix_plane_sr.sv
module bgpix_plane_sr #(
    parameter int TILE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pix_en,
    input  logic                  load,
    input  logic [TILE_W-1:0]     byte_in,
    output logic [2*TILE_W-1:0]   sr
);
    localparam int SR_W = 2 * TILE_W;

    logic [SR_W-1:0]   sr_q;
    logic [TILE_W-1:0] flipped;

    // Leftmost pixel (byte MSB) must reach bit 0 first.
    for (genvar i = 0; i < TILE_W; i++) begin : g_flip
        assign flipped[i] = byte_in[TILE_W-1-i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (pix_en) begin
            if (load) begin
                sr_q <= {flipped, sr_q[TILE_W:1]};
            end else begin
                sr_q <= {1'b0, sr_q[SR_W-1:1]};
            end
        end
    end

    assign sr = sr_q;
endmodule

// File: rtl/bgpix_attr_sr.sv
module bgpix_attr_sr #(
    parameter int TILE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic              load,
    input  logic              sel_in,
    output logic [TILE_W-1:0] sr
);
    logic              hold_q;
    logic [TILE_W-1:0] sr_q;

    // The latch feeds the serial input; on a load edge the old value
    // still shifts in, so a new tile enters one enabled edge later.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            sr_q   <= '0;
        end else if (pix_en) begin
            sr_q <= {hold_q, sr_q[TILE_W-1:1]};
            if (load) begin
                hold_q <= sel_in;
            end
        end
    end

    assign sr = sr_q;
endmodule

// File: rtl/bgpix_shifter.sv
module bgpix_shifter
    import bgpix_shifter_pkg::*;
#(
    parameter int TILE_W = 8,
    localparam int TAP_W = $clog2(TILE_W),
    localparam int SR_W  = 2 * TILE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic              load,
    input  logic [TILE_W-1:0] plane_lo,
    input  logic [TILE_W-1:0] plane_hi,
    input  logic [1:0]        attr,
    input  logic [TAP_W-1:0]  fine_x,
    output logic [3:0]        pix_idx
);
    logic [1:0][TILE_W-1:0] plane_bytes;
    logic [1:0][SR_W-1:0]   pat_sr;
    logic [1:0][TILE_W-1:0] at_sr;
    bg_index_t              idx;

    assign plane_bytes[0] = plane_lo;
    assign plane_bytes[1] = plane_hi;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bgpix_plane_sr #(.TILE_W(TILE_W)) u_plane (
            .clk     (clk),
            .rst     (rst),
            .pix_en  (pix_en),
            .load    (load),
            .byte_in (plane_bytes[g]),
            .sr      (pat_sr[g])
        );
        bgpix_attr_sr #(.TILE_W(TILE_W)) u_attr (
            .clk     (clk),
            .rst     (rst),
            .pix_en  (pix_en),
            .load    (load),
            .sel_in  (attr[g]),
            .sr      (at_sr[g])
        );
    end

    // Fine scroll is one shared tap on all four registers.
    always_comb begin
        idx.pal_hi = at_sr[1][fine_x];
        idx.pal_lo = at_sr[0][fine_x];
        idx.pat_hi = pat_sr[1][fine_x];
        idx.pat_lo = pat_sr[0][fine_x];
    end

    assign pix_idx = idx;
endmodule

// File: rtl/bgpix_shifter_chk.sv
module bgpix_shifter_chk #(
    parameter int TILE_W = 8,
    localparam int SR_W  = 2 * TILE_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   pix_en,
    input logic                   load,
    input logic [TILE_W-1:0]      plane_lo,
    input logic [TILE_W-1:0]      plane_hi,
    input logic [1:0]             attr,
    input logic [3:0]             pix_idx,
    input logic [1:0][SR_W-1:0]   pat_sr,
    input logic [1:0][TILE_W-1:0] at_sr
);
    function automatic logic [TILE_W-1:0] mirror(input logic [TILE_W-1:0] v);
        logic [TILE_W-1:0] r;
        for (int i = 0; i < TILE_W; i++) r[i] = v[TILE_W-1-i];
        return r;
    endfunction

    // R1: reset empties everything and the index reads zero
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pat_sr == '0 && at_sr == '0 && pix_idx == 4'd0));

    // R2: plain enabled shift feeds a zero at the top
    p_plane_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !load) |=>
            (pat_sr[0] == {1'b0, $past(pat_sr[0][SR_W-1:1])} &&
             pat_sr[1] == {1'b0, $past(pat_sr[1][SR_W-1:1])}));

    // R3: load shifts first, then writes the mirrored byte to the top
    p_plane_load_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_en && load) |=>
            (pat_sr[0][SR_W-1:TILE_W] == mirror($past(plane_lo)) &&
             pat_sr[1][SR_W-1:TILE_W] == mirror($past(plane_hi)) &&
             pat_sr[0][TILE_W-1:0] == $past(pat_sr[0][TILE_W:1]) &&
             pat_sr[1][TILE_W-1:0] == $past(pat_sr[1][TILE_W:1])));

    // R4: attribute enters on the enabled edge after its load edge
    p_attr_feed_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_en && load) ##1 pix_en |=>
            (at_sr[0][TILE_W-1] == $past(attr[0], 2) &&
             at_sr[1][TILE_W-1] == $past(attr[1], 2)));

    // R4: attribute registers move toward bit 0 on every enabled edge
    p_attr_shift_r4: assert property (@(posedge clk) disable iff (rst)
        pix_en |=>
            (at_sr[0][TILE_W-2:0] == $past(at_sr[0][TILE_W-1:1]) &&
             at_sr[1][TILE_W-2:0] == $past(at_sr[1][TILE_W-1:1])));

    // R7: disabled edges leave every register untouched
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(pat_sr) && $stable(at_sr)));
endmodule

bind bgpix_shifter bgpix_shifter_chk #(.TILE_W(TILE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pix_en   (pix_en),
    .load     (load),
    .plane_lo (plane_lo),
    .plane_hi (plane_hi),
    .attr     (attr),
    .pix_idx  (pix_idx),
    .pat_sr   (pat_sr),
    .at_sr    (at_sr)
);

// File: tb/bgpix_shifter_test.sv
module bgpix_shifter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] plane_lo = 8'h00;
    logic [7:0] plane_hi = 8'h00;
    logic [1:0] attr = 2'b00;
    logic [2:0] fine_x = 3'd0;
    wire  [3:0] pix_idx;

    int checks = 0;
    int errors = 0;
    int cnt = 0;          // enabled edges since reset left
    bit prev_en = 1'b1;
    bit done = 1'b0;

    logic [7:0] t_lo [0:511];
    logic [7:0] t_hi [0:511];
    logic [1:0] t_at [0:511];

    bgpix_shifter uut (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .load     (load),
        .plane_lo (plane_lo),
        .plane_hi (plane_hi),
        .attr     (attr),
        .fine_x   (fine_x),
        .pix_idx  (pix_idx)
    );

    always #10 clk = ~clk;

    // Expected index after cc enabled edges with scroll n (R5, R6).
    function automatic logic [3:0] expect_idx(input int cc, input int n);
        int q, j, p;
        q = cc - 16 + n;
        if (q < 0) return 4'd0;
        j = q / 8;
        p = q % 8;
        return {t_at[j], t_hi[j][7-p], t_lo[j][7-p]};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cnt=%0d fine=%0d actual=%h expected=%h", req, cnt, fine_x, act, exp);
        end
    endtask

    task automatic check_stream();
        int q;
        string req;
        q = cnt - 16 + int'(fine_x);
        if (q < 0) req = "R1";
        else if (!prev_en) req = "R7";
        else if (q % 8 == 0) req = "R6";
        else req = "R2 R3 R4 R5 R8";
        check(req, pix_idx, expect_idx(cnt, int'(fine_x)));
    endtask

    function automatic logic [7:0] directed_byte(input int j);
        case (j)
            0: return 8'h80;
            1: return 8'h01;
            2: return 8'hF0;
            3: return 8'hA5;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pix_en = 1'b0; load = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cnt = 0;
        prev_en = 1'b1;
        for (int f = 0; f < 8; f++) begin
            fine_x = 3'(f);
            #1;
            check("R1", pix_idx, 4'd0);
        end
    endtask

    // fmode < 0 picks a random scroll every cycle
    task automatic run_until(input int limit, input int fmode, input int gap_pct);
        int j;
        while (cnt < limit) begin
            @(negedge clk);
            check_stream();
            pix_en = ($urandom_range(99) >= gap_pct);
            fine_x = (fmode < 0) ? 3'($urandom) : 3'(fmode);
            if (pix_en && (cnt % 8 == 7)) begin
                j = cnt / 8;
                t_lo[j] = directed_byte(j);
                t_hi[j] = ~directed_byte(j);
                t_at[j] = 2'($urandom);
                plane_lo = t_lo[j];
                plane_hi = t_hi[j];
                attr = t_at[j];
                load = 1'b1;
            end else begin
                // junk that must be ignored (R7 when disabled)
                plane_lo = 8'($urandom);
                plane_hi = 8'($urandom);
                attr = 2'($urandom);
                load = !pix_en && ($urandom_range(1) == 1);
            end
            prev_en = pix_en;
            @(posedge clk);
            if (pix_en) cnt++;
        end
        @(negedge clk);
        load = 1'b0;
        pix_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state seen before any edge with rst low
        @(negedge clk);
        check("R1", pix_idx, 4'd0);
        do_reset();
        run_until(120, 0, 0);     // scroll 0, no gaps, directed bytes first
        run_until(240, 7, 0);     // scroll 7 boundary
        run_until(600, -1, 30);   // random scroll with enable gaps (R7)
        do_reset();               // mid-stream reset (R1)
        run_until(400, -1, 20);
        run_until(520, 3, 50);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule